// File: doc/BRIEF.md
# Manchester Receive Drift Compensator

This block recovers bit timing for a Manchester-coded serial line that is sampled with a clock running at sixteen times the bit rate. A phase counter runs through each bit period and expects the mid-bit transition at count 8. Every transition seen on the synchronized line is compared with that expected count. A deviation of one clock or less is treated as jitter. A transition that falls inside the early window makes the current period one clock shorter. A transition inside the late window makes it one clock longer. The receiver can then follow a transmitter whose clock drifts slowly.

Once per bit, a quarter bit after the expected mid-bit point, the block issues a sample strobe and latches the decoded bit. Separate single-cycle pulses report a shortened period, a lengthened period, and a transition that lies outside every window. A single enable input turns compensation on. While it is clear, the period stays fixed at sixteen clocks and no report pulse is raised. Frame sync detection and character assembly belong to the stages that follow this block.

Top module: `manch_drift_track`

## Requirements
- R1: A change on `rxd_i` passes through a two-flop synchronizer and one further history flop. The change is classified at the third rising clock edge after it is applied, and any resulting report pulse is visible right after that edge.
- R2: While `comp_en_i` is 0, every bit period lasts 16 clocks and `shorten_o`, `lengthen_o` and `stray_o` stay 0.
- R3: The phase count runs 0..15 in a nominal period, and the expected mid-bit transition is at count 8. A transition at count 7, 8 or 9 (deviation -1..+1) is jitter: it raises no pulse and leaves the period length unchanged.
- R4: With compensation on, a transition at count 4, 5 or 6 (2 to 4 clocks early) raises `shorten_o` for one cycle and makes the current period 15 clocks long.
- R5: With compensation on, a transition at count 10 or 11 (2 or 3 clocks late) raises `lengthen_o` for one cycle and makes the current period 17 clocks long.
- R6: With compensation on, any other transition raises `stray_o` for one cycle and does not change the period. At most one of the three report pulses is high in any cycle.
- R7: At most one correction is applied per bit period. Later early or late transitions in the same period produce no pulse and no change. The period length returns to 16 at each wrap.
- R8: `sample_strb_o` is a single-cycle pulse, visible after the edge at which the phase count is 12. After reset, the first strobe therefore follows the 13th rising edge. Strobes are separated by the current period length.
- R9: On each strobe, `bit_o` takes the synchronized line level, so a high-to-low mid-bit transition decodes as 0 and a low-to-high one as 1. Between strobes, `bit_o` holds its value.
- R10: During reset (`rst_ni` = 0), all outputs are 0, the phase count is 0 and the synchronizer holds the idle-high level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock, 16 per bit |
| rst_ni | input | 1 | Synchronous active-low reset |
| rxd_i | input | 1 | Asynchronous receive line |
| comp_en_i | input | 1 | 1 enables drift compensation |
| sample_strb_o | output | 1 | One-cycle strobe per bit |
| bit_o | output | 1 | Recovered bit, valid from the strobe |
| shorten_o | output | 1 | One-cycle pulse: period shortened |
| lengthen_o | output | 1 | One-cycle pulse: period lengthened |
| stray_o | output | 1 | One-cycle pulse: transition outside every window |

## Verification
The hardest situation to reach from the ports is two correctable transitions inside one period, where only the first may take effect. The phase count is hidden, so the bench brings every directed case up from a fresh reset. There the count is known exactly from the cycle number, and it places a transition at count 5 with a second at count 6. It confirms a single shorten pulse and a next strobe 15 clocks later. Random Manchester streams with half-bit lengths of 5 to 11 clocks, and with the enable toggling, then drive the model comparison through every window edge.

// File: rtl/manch_drift_pkg.sv
// Shared types for the Manchester drift compensator.
// Assumes: one transition classification per clock at most.
package manch_drift_pkg;
    typedef enum logic [1:0] {
        ZONE_NONE  = 2'd0,
        ZONE_EARLY = 2'd1,
        ZONE_LATE  = 2'd2,
        ZONE_STRAY = 2'd3
    } zone_e;
endpackage

// File: rtl/manch_line_sync.sv
// Brings the asynchronous line into the clock domain and flags transitions.
// Assumes: the line idles high; a transition is reported for one cycle.
module manch_line_sync (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_i,
    output logic lvl_o,
    output logic edge_o
);
    logic meta_q, lvl_q, prev_q;

    // Two-flop synchronizer plus one history flop for transition detection.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            meta_q <= 1'b1;
            lvl_q  <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= line_i;
            lvl_q  <= meta_q;
            prev_q <= lvl_q;
        end
    end

    assign lvl_o  = lvl_q;
    assign edge_o = lvl_q ^ prev_q;
endmodule

// File: rtl/manch_edge_judge.sv
// Classifies a transition by its distance from the expected mid-bit count.
// Assumes: windows do not overlap and lie inside one period.
module manch_edge_judge
    import manch_drift_pkg::*;
#(
    parameter int CW        = 5,
    parameter int MID       = 8,
    parameter int JIT_TOL   = 1,
    parameter int EARLY_MIN = 2,
    parameter int EARLY_MAX = 4,
    parameter int LATE_MIN  = 2,
    parameter int LATE_MAX  = 3
) (
    input  logic          edge_i,
    input  logic [CW-1:0] phase_i,
    output zone_e         zone_o
);
    localparam int W = CW + 1;
    localparam logic signed [CW:0] MID_S  = W'(MID);
    localparam logic signed [CW:0] JIT_LO = W'(-JIT_TOL);
    localparam logic signed [CW:0] JIT_HI = W'(JIT_TOL);
    localparam logic signed [CW:0] ERL_LO = W'(-EARLY_MAX);
    localparam logic signed [CW:0] ERL_HI = W'(-EARLY_MIN);
    localparam logic signed [CW:0] LAT_LO = W'(LATE_MIN);
    localparam logic signed [CW:0] LAT_HI = W'(LATE_MAX);

    logic signed [CW:0] dev;

    // Signed deviation of the current count from the expected mid-bit count.
    always_comb begin
        dev = $signed({1'b0, phase_i}) - MID_S;
    end

    // Window decision for the current transition.
    always_comb begin
        if (!edge_i) begin
            zone_o = ZONE_NONE;
        end else if (dev >= JIT_LO && dev <= JIT_HI) begin
            zone_o = ZONE_NONE;
        end else if (dev >= ERL_LO && dev <= ERL_HI) begin
            zone_o = ZONE_EARLY;
        end else if (dev >= LAT_LO && dev <= LAT_HI) begin
            zone_o = ZONE_LATE;
        end else begin
            zone_o = ZONE_STRAY;
        end
    end
endmodule

// File: rtl/manch_phase_ctr.sv
// Runs the per-bit phase count, applies at most one correction per period,
// and produces the sample strobe, recovered bit and report pulses.
// Assumes: SAMP is below the shortest period's last count.
module manch_phase_ctr
    import manch_drift_pkg::*;
#(
    parameter int OSR  = 16,
    parameter int CW   = 5,
    parameter int SAMP = 12
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          en_i,
    input  zone_e         zone_i,
    input  logic          lvl_i,
    output logic [CW-1:0] phase_o,
    output logic [CW-1:0] last_o,
    output logic          strb_o,
    output logic          bit_o,
    output logic          short_o,
    output logic          long_o,
    output logic          stray_o
);
    localparam logic [CW-1:0] NOM_LAST  = CW'(OSR - 1);
    localparam logic [CW-1:0] SHRT_LAST = CW'(OSR - 2);
    localparam logic [CW-1:0] LONG_LAST = CW'(OSR);
    localparam logic [CW-1:0] SAMP_C    = CW'(SAMP);

    logic [CW-1:0] phase_q, last_q;
    logic          done_q, wrap, take_early, take_late;

    // Correction requests gated by enable and the one-per-period rule.
    always_comb begin
        wrap       = (phase_q == last_q);
        take_early = en_i && !done_q && (zone_i == ZONE_EARLY);
        take_late  = en_i && !done_q && (zone_i == ZONE_LATE);
    end

    // Phase count and period length for the current bit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            phase_q <= '0;
            last_q  <= NOM_LAST;
            done_q  <= 1'b0;
        end else if (wrap) begin
            phase_q <= '0;
            last_q  <= NOM_LAST;
            done_q  <= 1'b0;
        end else begin
            phase_q <= phase_q + 1'b1;
            if (take_early) begin
                last_q <= SHRT_LAST;
                done_q <= 1'b1;
            end else if (take_late) begin
                last_q <= LONG_LAST;
                done_q <= 1'b1;
            end
        end
    end

    // Single-cycle report pulses.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            short_o <= 1'b0;
            long_o  <= 1'b0;
            stray_o <= 1'b0;
        end else begin
            short_o <= take_early && !wrap;
            long_o  <= take_late && !wrap;
            stray_o <= en_i && (zone_i == ZONE_STRAY);
        end
    end

    // Quarter-bit-late sample strobe and recovered bit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            strb_o <= 1'b0;
            bit_o  <= 1'b0;
        end else begin
            strb_o <= (phase_q == SAMP_C);
            if (phase_q == SAMP_C) begin
                bit_o <= lvl_i;
            end
        end
    end

    assign phase_o = phase_q;
    assign last_o  = last_q;
endmodule

// File: rtl/manch_drift_track.sv
// Top of the Manchester receive drift compensator: synchronizer, window
// judge and phase counter. Assumes 16x oversampling of the receive line.
module manch_drift_track #(
    parameter int OSR       = 16,
    parameter int JIT_TOL   = 1,
    parameter int EARLY_MIN = 2,
    parameter int EARLY_MAX = 4,
    parameter int LATE_MIN  = 2,
    parameter int LATE_MAX  = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rxd_i,
    input  logic comp_en_i,
    output logic sample_strb_o,
    output logic bit_o,
    output logic shorten_o,
    output logic lengthen_o,
    output logic stray_o
);
    import manch_drift_pkg::*;

    localparam int CW   = $clog2(OSR + 2);
    localparam int MID  = OSR / 2;
    localparam int SAMP = MID + OSR / 4;

    logic          lvl_w, edge_w;
    logic [CW-1:0] phase_w, last_w;
    zone_e         zone_w;

    manch_line_sync u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .line_i (rxd_i),
        .lvl_o  (lvl_w),
        .edge_o (edge_w)
    );

    manch_edge_judge #(
        .CW(CW), .MID(MID), .JIT_TOL(JIT_TOL),
        .EARLY_MIN(EARLY_MIN), .EARLY_MAX(EARLY_MAX),
        .LATE_MIN(LATE_MIN), .LATE_MAX(LATE_MAX)
    ) u_judge (
        .edge_i  (edge_w),
        .phase_i (phase_w),
        .zone_o  (zone_w)
    );

    manch_phase_ctr #(
        .OSR(OSR), .CW(CW), .SAMP(SAMP)
    ) u_phase (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (comp_en_i),
        .zone_i  (zone_w),
        .lvl_i   (lvl_w),
        .phase_o (phase_w),
        .last_o  (last_w),
        .strb_o  (sample_strb_o),
        .bit_o   (bit_o),
        .short_o (shorten_o),
        .long_o  (lengthen_o),
        .stray_o (stray_o)
    );
endmodule

// File: rtl/manch_drift_track_chk.sv
// Property checker for manch_drift_track, attached with bind below.
// Assumes: phase and period-end counts are brought in from the top's nets.
module manch_drift_track_chk #(
    parameter int OSR = 16,
    parameter int CW  = 5
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          comp_en_i,
    input logic          sample_strb_o,
    input logic          bit_o,
    input logic          shorten_o,
    input logic          lengthen_o,
    input logic          stray_o,
    input logic [CW-1:0] phase_w,
    input logic [CW-1:0] last_w
);
    localparam logic [CW-1:0] NOM_LAST = CW'(OSR - 1);

    a_r2_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !comp_en_i |=> !(shorten_o || lengthen_o || stray_o));

    a_r4_short_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shorten_o |-> last_w == CW'(OSR - 2));

    a_r5_long_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lengthen_o |-> last_w == CW'(OSR));

    a_r6_one_report: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({shorten_o, lengthen_o, stray_o}));

    a_r7_single_fix: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (last_w != NOM_LAST && phase_w != last_w) |=> $stable(last_w));

    a_r8_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_strb_o |=> !sample_strb_o);

    a_r8_phase_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        phase_w <= last_w);

    a_r9_bit_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sample_strb_o |-> $stable(bit_o));

    a_r10_reset_clear: assert property (@(posedge clk_i)
        !rst_ni |=> (phase_w == '0 && !sample_strb_o && !shorten_o && !lengthen_o && !stray_o));
endmodule

bind manch_drift_track manch_drift_track_chk #(.OSR(OSR), .CW(CW)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .comp_en_i     (comp_en_i),
    .sample_strb_o (sample_strb_o),
    .bit_o         (bit_o),
    .shorten_o     (shorten_o),
    .lengthen_o    (lengthen_o),
    .stray_o       (stray_o),
    .phase_w       (phase_w),
    .last_w        (last_w)
);

// File: tb/manch_drift_track_tb.sv
// Bench for manch_drift_track: behavioural reference compared every clock,
// plus directed cases placed at known phase counts from a fresh reset.
module manch_drift_track_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rxd = 1'b1;
    logic en = 1'b0;
    logic strb, bitv, sh, ln, oow;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int n_sh = 0, n_ln = 0, n_oow = 0;
    int strb_at[$];
    bit finished = 1'b0;

    // reference model state
    bit pipe[$] = '{1'b1, 1'b1, 1'b1};
    int m_phase = 0, m_len = 16;
    bit m_fixed = 1'b0;
    bit m_strb = 1'b0, m_bit = 1'b0, m_sh = 1'b0, m_ln = 1'b0, m_oow = 1'b0;

    manch_drift_track u_dut (
        .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .comp_en_i(en),
        .sample_strb_o(strb), .bit_o(bitv), .shorten_o(sh),
        .lengthen_o(ln), .stray_o(oow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference model, evaluated on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            pipe = '{1'b1, 1'b1, 1'b1};
            m_phase = 0; m_len = 16; m_fixed = 0;
            m_strb = 0; m_bit = 0; m_sh = 0; m_ln = 0; m_oow = 0;
            cyc = 0;
        end else begin
            int d;
            bit e;
            bit lvl;
            cyc++;
            lvl = pipe[1];
            e = (pipe[1] != pipe[2]);
            d = m_phase - 8;
            m_sh = 0; m_ln = 0; m_oow = 0;
            m_strb = (m_phase == 12);
            if (m_strb) m_bit = lvl;
            if (e && en && !(d >= -1 && d <= 1)) begin
                if (d >= -4 && d <= -2) m_sh = !m_fixed;
                else if (d >= 2 && d <= 3) m_ln = !m_fixed;
                else m_oow = 1;
            end
            if (m_phase == m_len - 1) begin
                m_phase = 0; m_len = 16; m_fixed = 0;
            end else begin
                m_phase++;
                if (m_sh) begin m_len = 15; m_fixed = 1; end
                else if (m_ln) begin m_len = 17; m_fixed = 1; end
            end
            pipe.push_front(rxd);
            void'(pipe.pop_back());
        end
    end

    // Compare every clock and gather pulse statistics away from the edge.
    always @(negedge clk) begin
        if (rst_n && cyc > 0) begin
            chk(strb == m_strb, "R8", "strobe", int'(strb), int'(m_strb));
            chk(bitv == m_bit, "R9", "bit", int'(bitv), int'(m_bit));
            chk(sh == m_sh, "R4", "shorten", int'(sh), int'(m_sh));
            chk(ln == m_ln, "R5", "lengthen", int'(ln), int'(m_ln));
            chk(oow == m_oow, "R6", "stray", int'(oow), int'(m_oow));
            if (sh) n_sh++;
            if (ln) n_ln++;
            if (oow) n_oow++;
            if (strb) strb_at.push_back(cyc);
        end
    end

    task automatic do_reset(input bit en_v);
        @(negedge clk);
        rst_n = 0; rxd = 1; en = en_v;
        repeat (3) @(negedge clk);
        chk(!strb && !bitv && !sh && !ln && !oow, "R10", "outputs in reset",
            int'({strb, bitv, sh, ln, oow}), 0);
        rst_n = 1;
        n_sh = 0; n_ln = 0; n_oow = 0;
        strb_at.delete();
    endtask

    // Place a transition so it is classified at phase count c of period 1.
    task automatic probe(input int c, input bit en_v, input int e_sh,
                         input int e_ln, input int e_oow, input string req);
        do_reset(en_v);
        repeat (c - 2) @(posedge clk);
        @(negedge clk) rxd = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(!sh && !ln && !oow, "R1", "no pulse before third edge",
            int'({sh, ln, oow}), 0);
        @(posedge clk);
        @(negedge clk);
        chk(int'(sh) == e_sh, req, "shorten at third edge", int'(sh), e_sh);
        chk(int'(ln) == e_ln, req, "lengthen at third edge", int'(ln), e_ln);
        chk(int'(oow) == e_oow, req, "stray at third edge", int'(oow), e_oow);
    endtask

    task automatic second_strobe(input int exp, input string req);
        while (strb_at.size() < 2) @(negedge clk);
        chk(strb_at[0] == 13, "R8", "first strobe cycle", strb_at[0], 13);
        chk(strb_at[1] == exp, req, "second strobe cycle", strb_at[1], exp);
    endtask

    task automatic stream(input int nbits, input int hmin, input int hspan,
                          input bit toggle_en);
        for (int i = 0; i < nbits; i++) begin
            bit b;
            int h1, h2;
            b = 1'($urandom % 2);
            h1 = hmin + int'($urandom % hspan);
            h2 = hmin + int'($urandom % hspan);
            if (toggle_en && ($urandom % 8 == 0)) en = ~en;
            rxd = !b;
            repeat (h1) @(negedge clk);
            rxd = b;
            repeat (h2) @(negedge clk);
        end
    endtask

    initial begin
        // R3 jitter, R4/R5 windows, R6 stray, R2 disabled
        probe(7, 1, 0, 0, 0, "R3");
        probe(9, 1, 0, 0, 0, "R3");
        probe(4, 1, 1, 0, 0, "R4");
        probe(6, 1, 1, 0, 0, "R4");
        probe(5, 1, 1, 0, 0, "R4");
        second_strobe(28, "R4");
        probe(10, 1, 0, 1, 0, "R5");
        probe(11, 1, 0, 1, 0, "R5");
        second_strobe(30, "R5");
        probe(3, 1, 0, 0, 1, "R6");
        probe(12, 1, 0, 0, 1, "R6");
        second_strobe(29, "R6");
        probe(5, 0, 0, 0, 0, "R2");
        second_strobe(29, "R2");

        // R7: transitions at counts 5 and 6 in one period
        do_reset(1);
        repeat (3) @(posedge clk);
        @(negedge clk) rxd = 0;
        @(negedge clk) rxd = 1;
        second_strobe(28, "R7");
        chk(n_sh == 1 && n_ln == 0, "R7", "corrections in period", n_sh, 1);

        // R9: falling mid-bit -> 0, rising mid-bit -> 1
        do_reset(1);
        repeat (6) @(posedge clk);
        @(negedge clk) rxd = 0;
        while (strb_at.size() < 1) @(negedge clk);
        chk(bitv == 1'b0, "R9", "falling mid-bit decodes 0", int'(bitv), 0);
        while (cyc < 22) @(negedge clk);
        rxd = 1;
        while (strb_at.size() < 2) @(negedge clk);
        chk(bitv == 1'b1, "R9", "rising mid-bit decodes 1", int'(bitv), 1);

        // random streams: nominal, fast, slow, wide, enable toggling
        do_reset(1);
        stream(200, 7, 3, 0);
        stream(200, 7, 2, 0);
        stream(200, 8, 2, 0);
        stream(200, 5, 7, 0);
        stream(300, 6, 5, 1);
        do_reset(0);
        stream(100, 6, 5, 0);
        chk(n_sh == 0 && n_ln == 0 && n_oow == 0, "R2", "no pulses while off",
            n_sh + n_ln + n_oow, 0);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule